// File: doc/BRIEF.md
# Line-Doubled Framebuffer Scanout Streamer

This block streams one scan line of pixel bytes from a framebuffer to an 8-bit pixel output each time the display timing logic signals the start of a line. It issues addresses to a framebuffer read port that has one cycle of latency. The addresses run one cycle ahead of the pixels, so a line of `LINE_LEN` bytes leaves at one byte per clock with no gaps. When the last byte of a line has been shown, the output falls to zero and stays at zero until the next line, so the pixel level is black for the rest of the line.

Each stored row is shown on two consecutive display lines. A row pointer is held at the framebuffer base address while the visible flag is low, so it reloads at the start of every visible region. After each line it moves forward by one row only if the following line index is even. If the move would reach the end of the screen area (base plus `LINE_LEN*ROWS`), the pointer returns to the base address.

A line-start strobe is accepted only while the visible flag is high and the block is idle. A strobe that arrives during a transfer is dropped and sets a sticky overrun flag, which only reset clears. The control is a four-state machine:
- `ST_IDLE`: waiting for a line start.
- `ST_STREAM`: issuing `LINE_LEN` reads.
- `ST_DRAIN`: the final read is returning.
- `ST_LAST`: the last byte is on the output.

Its transitions:
- `ST_IDLE` to `ST_STREAM`, on an accepted start.
- `ST_STREAM` to `ST_DRAIN`, after the read at count `LINE_LEN-1`.
- `ST_DRAIN` to `ST_LAST`, unconditionally.
- `ST_LAST` to `ST_IDLE`, unconditionally. This is the line-done point, where the row pointer may advance.

Top module: `line_scanout_streamer`

## Requirements
- R1: After a line start is accepted at clock edge E0, the byte stored at line pointer + k appears on `pix_out` after edge E(k+2), for k = 0 to `LINE_LEN`-1 (160 by default). Consecutive addresses give one byte per clock.
- R2: A line start is accepted only if `visible` is high at the same edge. Otherwise it has no effect on `pix_out`, `busy`, `rd_en` or `overrun`.
- R3: `pix_out` is zero during reset, zero from edge E(`LINE_LEN`+2) onward (the forced zero byte that ends the line), and zero whenever no line is being shown.
- R4: While `visible` is low, the row pointer is held at `BASE_ADDR`, so the first line of a visible region reads from the base address.
- R5: At the line-done edge, the row pointer advances by `LINE_LEN` only if bit 0 of the `line_idx` captured with that line was 1, meaning the next line index is even. Otherwise the next line repeats the same row.
- R6: An advance that would make the row pointer reach or pass `BASE_ADDR + LINE_LEN*ROWS` sets it to `BASE_ADDR` instead.
- R7: `rd_en` is high exactly after edges E0 to E(`LINE_LEN`-1), with `rd_addr` = line pointer + (cycles since E0), one cycle ahead of the byte it fetches.
- R8: `busy` is high from just after E0 until edge E(`LINE_LEN`+2), and low otherwise.
- R9: A line start that arrives while `busy` is high is ignored and sets `overrun`. `overrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe marking the start of a scan line |
| visible | input | 1 | High while the visible region of the frame is active |
| line_idx | input | IDX_W | Index of the line being started |
| rd_data | input | PIX_W | Framebuffer read data, valid one cycle after the read is issued |
| rd_en | output | 1 | Framebuffer read request |
| rd_addr | output | ADDR_W | Framebuffer byte address |
| pix_out | output | PIX_W | Pixel byte output |
| busy | output | 1 | A line transfer is in progress |
| overrun | output | 1 | Sticky flag: a line start arrived while busy |

## Verification
The hardest situation to reach is the row-pointer wrap. It needs a full sequence of line transfers with alternating index parity before the pointer reaches the end of the screen area. The bench builds the block with only three rows and runs eight consecutive visible lines, so the wrap occurs on the sixth transfer. Every byte is compared against a behavioural model that follows row reuse and wrap from the indices alone. Overrun is produced by a second strobe in the middle of a transfer. A base reload is produced by lowering `visible` between lines and resuming with an odd line index.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_LAST   = 2'd3
    } scan_state_t;
endpackage

// File: rtl/scan_row_tracker.sv
module scan_row_tracker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LINE_LEN  = 160,
    parameter int unsigned ROWS      = 120,
    parameter int unsigned BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visible,
    input  logic              line_done,
    input  logic              adv_req,
    output logic [ADDR_W-1:0] row_addr
);
    localparam int unsigned SCREEN_BYTES = LINE_LEN * ROWS;
    localparam logic [ADDR_W:0]   LIMIT  = (ADDR_W+1)'(BASE_ADDR + SCREEN_BYTES);
    localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W:0]   STRIDE = (ADDR_W+1)'(LINE_LEN);

    logic [ADDR_W:0] stepped;
    logic            wraps;

    // Candidate next row and its wrap test, one bit wider to catch carry.
    always_comb begin
        stepped = {1'b0, row_addr} + STRIDE;
        wraps   = (stepped >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr <= BASE;
        end else if (!visible) begin
            row_addr <= BASE;                       // R4 reload outside visible region
        end else if (line_done && adv_req) begin    // R5 advance on odd captured index
            row_addr <= wraps ? BASE : stepped[ADDR_W-1:0];  // R6 wrap
        end
    end
endmodule

// File: rtl/scan_fetch_fsm.sv
module scan_fetch_fsm
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned LINE_LEN = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              visible,
    input  logic              idx_lsb,
    input  logic [ADDR_W-1:0] row_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              line_done,
    output logic              adv_req,
    output logic              overrun
);
    localparam int unsigned CNT_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_LEN - 1);

    scan_state_t       state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] line_ptr;
    logic              odd_q;
    logic              over_q;
    logic              accept;

    assign accept = (state == ST_IDLE) && line_start && visible;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nxt = ST_STREAM;
            ST_STREAM: if (cnt == CNT_LAST) state_nxt = ST_DRAIN;
            ST_DRAIN:  state_nxt = ST_LAST;
            ST_LAST:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            line_ptr <= '0;
            odd_q    <= 1'b0;
            over_q   <= 1'b0;
        end else begin
            if (line_start && (state != ST_IDLE)) over_q <= 1'b1;
            if (accept) begin
                cnt      <= '0;
                line_ptr <= row_addr;
                odd_q    <= idx_lsb;
            end else if (state == ST_STREAM && cnt != CNT_LAST) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_en     = (state == ST_STREAM);
        rd_addr   = line_ptr + ADDR_W'(cnt);
        busy      = (state != ST_IDLE);
        line_done = (state == ST_LAST);
        adv_req   = odd_q;
        overrun   = over_q;
    end
endmodule

// File: rtl/scan_pixel_pipe.sv
module scan_pixel_pipe #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [PIX_W-1:0] rd_data,
    output logic [PIX_W-1:0] pix_out
);
    logic valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pix_out <= '0;
        end else begin
            valid_q <= rd_en;
            pix_out <= valid_q ? rd_data : '0;  // zero whenever no byte returns
        end
    end
endmodule

// File: rtl/line_scanout_streamer.sv
module line_scanout_streamer #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned LINE_LEN  = 160,
    parameter int unsigned ROWS      = 120,
    parameter int unsigned BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              visible,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  pix_out,
    output logic              busy,
    output logic              overrun
);
    logic [ADDR_W-1:0] row_addr;
    logic              line_done;
    logic              adv_req;

    scan_row_tracker #(
        .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN), .ROWS(ROWS), .BASE_ADDR(BASE_ADDR)
    ) u_rows (
        .clk(clk), .rst_n(rst_n), .visible(visible),
        .line_done(line_done), .adv_req(adv_req), .row_addr(row_addr)
    );

    scan_fetch_fsm #(
        .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .visible(visible),
        .idx_lsb(line_idx[0]), .row_addr(row_addr),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
        .line_done(line_done), .adv_req(adv_req), .overrun(overrun)
    );

    scan_pixel_pipe #(
        .PIX_W(PIX_W)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .pix_out(pix_out)
    );
endmodule

// File: rtl/scan_streamer_checker.sv
module scan_streamer_checker #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              visible,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PIX_W-1:0]  pix_out,
    input logic              busy,
    input logic              overrun
);
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pix_out == '0));

    assert_read_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_start_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(visible) && $past(line_start)));
endmodule

bind line_scanout_streamer scan_streamer_checker #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) chk (.*);

// File: tb/line_scanout_streamer_test.sv
module line_scanout_streamer_test;
    localparam int LLEN = 160;
    localparam int NROW = 3;
    localparam int BASE = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        visible = 1'b0;
    logic [9:0]  line_idx = '0;
    logic [7:0]  rd_data = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  pix_out;
    logic        busy;
    logic        overrun;

    int vectors = 0;
    int miscompares = 0;
    string tag = "R3";
    bit done = 0;

    line_scanout_streamer #(
        .LINE_LEN(LLEN), .ROWS(NROW), .BASE_ADDR(BASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .visible(visible),
        .line_idx(line_idx), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .pix_out(pix_out), .busy(busy), .overrun(overrun)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] fb_byte(input int a);
        logic [7:0] x;
        x = 8'((a & 255) + (a >> 8) * 37);
        return {x[7:1], 1'b1};
    endfunction

    // framebuffer with one cycle read latency
    always @(posedge clk) if (rd_en) rd_data <= fb_byte(int'(rd_addr));

    // reference model: phase counter since accept
    int m_p = 0, m_row = BASE, m_ptr = 0;
    bit m_odd = 0, m_over = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_row = BASE; m_over = 0;
        end else begin
            bit fin;
            fin = (m_p == LLEN + 2);
            if (line_start && m_p != 0) m_over = 1;
            if (!visible) m_row = BASE;
            else if (fin && m_odd) begin
                m_row += LLEN;
                if (m_row >= BASE + LLEN * NROW) m_row = BASE;
            end
            if (m_p == 0 && line_start && visible) begin
                m_p = 1; m_ptr = m_row; m_odd = line_idx[0];
            end else if (fin) m_p = 0;
            else if (m_p != 0) m_p++;
        end
    end

    always @(negedge clk) if (!done) begin
        int  e_pix, e_addr;
        bit  e_busy, e_rd;
        e_pix  = (m_p >= 3 && m_p <= LLEN + 2) ? int'(fb_byte(m_ptr + m_p - 3)) : 0;
        e_busy = (m_p != 0);
        e_rd   = (m_p >= 1 && m_p <= LLEN);
        e_addr = m_ptr + m_p - 1;
        vectors++;
        if (int'(pix_out) != e_pix) begin
            miscompares++;
            $display("FAIL %s pix_out: actual=%0h expected=%0h (phase %0d)", tag, pix_out, e_pix, m_p);
        end
        if (busy != e_busy) begin
            miscompares++;
            $display("FAIL R8 busy: actual=%0b expected=%0b", busy, e_busy);
        end
        if (rd_en != e_rd || (e_rd && int'(rd_addr) != e_addr)) begin
            miscompares++;
            $display("FAIL R7 read: actual=%0b/%0h expected=%0b/%0h", rd_en, rd_addr, e_rd, e_addr);
        end
        if (overrun != m_over) begin
            miscompares++;
            $display("FAIL R9 overrun: actual=%0b expected=%0b", overrun, m_over);
        end
    end

    task automatic pulse_line(input int idx);
        @(posedge clk); #2;
        line_start = 1'b1; line_idx = 10'(idx);
        @(posedge clk); #2;
        line_start = 1'b0;
    endtask

    task automatic run_line(input int idx);
        pulse_line(idx);
        repeat (170) @(posedge clk);
    endtask

    initial begin
        tag = "R3";                       // reset state and idle zero
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (5) @(posedge clk);

        tag = "R2";                       // start ignored while not visible
        run_line(4);

        #2 visible = 1'b1;
        tag = "R1";  run_line(10);        // first row, full line bytes
        tag = "R5";  run_line(11);        // same row repeated, then advance
        run_line(12); run_line(13);
        tag = "R6";  run_line(14); run_line(15); // last row, then wrap
        run_line(16); run_line(17);

        tag = "R9";                       // mid-line start dropped
        pulse_line(18);
        repeat (40) @(posedge clk);
        pulse_line(19);
        repeat (170) @(posedge clk);

        tag = "R4";                       // reload after leaving visible region
        @(posedge clk); #2 visible = 1'b0;
        repeat (10) @(posedge clk);
        #2 visible = 1'b1;
        run_line(21); run_line(22);
        tag = "R3";  run_line(23);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule